// File: doc/BRIEF.md
# Black-Level Clamp Servo

This block closes a digital black-level loop for one video channel. Once per line it measures the back porch: it waits a programmed number of valid pixels after the falling edge of the horizontal sync, then averages a window of ADC samples. It averages those per-line results over a group of lines. At the end of each group it nudges a signed 10-bit offset DAC code one step toward the point where the back-porch level equals four times an 8-bit per-channel target.

Measurement is held off while the line PLL reports that it is coasting, unless an override is set. A manual mode bypasses the loop and drives the DAC code from the user offset. In automatic mode the same user offset is instead added digitally to the outgoing samples. A half-range mode makes the comparison work in half-code steps, to match a DAC whose step is half an ADC code.

Top module: `blk_level_servo`

## Requirements
- R1: During and straight after a synchronous reset (`rst` high), `dac_code` reads 0 and `out_valid` reads 0.
- R2: With `cfg_manual` = 1, `dac_code` equals `cfg_user_ofs` (signed), `out_data` is `px_data` unchanged one clock later, and no line is measured, so the servo code held for automatic mode does not move.
- R3: A measurement starts only on a high-to-low transition of `hsync` seen on two consecutive clock edges. Each such edge gives at most one measurement, so one group step per line group.
- R4: After the edge, the first `cfg_delay` pixels with `px_valid` = 1 are skipped. Counting starts with the pixel accepted on the clock after the one on which `hsync` is first sampled low. Cycles with `px_valid` = 0 are neither counted nor sampled. The delay covers the full 16-bit range.
- R5: The window holds 16 << `cfg_win_sel` valid pixels (16, 32, 64, 128). Their sum is reduced by a right shift to a line average held with one fractional bit.
- R6: A group holds 1 << `cfg_lines_sel` lines (1 to 128). The DAC code can change only after the last line of a group.
- R7: At the end of a group, `dac_code` (two's complement) rises by 1 if the group average is below `cfg_target`×4 codes, falls by 1 if it is above, and holds if they are equal.
- R8: The servo code saturates at +511 and -512 and never wraps.
- R9: While `pll_coast` = 1 and `cfg_coast_override` = 0, no measurement starts. With the override at 1, coasting has no effect.
- R10: With `cfg_half_range` = 1, the group average keeps its half-code bit and is compared with `cfg_target`×8 half codes. A back-porch mean of 16.5 against a target of 16 then steps the code down, where full-range mode holds.
- R11: In automatic mode, `out_data` is `px_data` plus the signed `cfg_user_ofs`, clamped to 0..1023. It is registered one clock after the input, and `out_valid` follows `px_valid` one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| px_valid | input | 1 | Pixel strobe for `px_data` |
| px_data | input | 10 | ADC sample |
| hsync | input | 1 | Horizontal sync, active high; the measurement starts at its falling edge |
| pll_coast | input | 1 | Line PLL is coasting |
| cfg_manual | input | 1 | 1 = manual offset, 0 = servo active |
| cfg_coast_override | input | 1 | 1 = measure even while coasting |
| cfg_half_range | input | 1 | 1 = DAC step is half an ADC code |
| cfg_delay | input | 16 | Valid pixels skipped after the sync edge |
| cfg_win_sel | input | 2 | Window size select (16 << n pixels) |
| cfg_lines_sel | input | 3 | Line group select (1 << n lines) |
| cfg_target | input | 8 | Black target, in units of 4 codes |
| cfg_user_ofs | input | 10 | Signed user offset |
| out_valid | output | 1 | Strobe for `out_data` |
| out_data | output | 10 | Offset-adjusted sample |
| dac_code | output | 10 | Signed offset DAC code |

## Verification
A plant model in the bench feeds back `black + dac_code` (halved in half-range mode). Convergence runs cover several delays, window sizes, group sizes and sync-to-window spacings, with pixels before and after the window driven bright. An early, late or over-long window would therefore settle on the wrong level. Gaps in `px_valid` carry bright data, so counting or sampling an invalid cycle shows up. Single-group directed runs separate the cases that a long run hides. Split-level windows tell 16, 32 and 64 pixel windows apart. A window alternating 16 and 17 tells half-code resolution from whole-code resolution. Line-by-line counts show when a group ends. Coasting with and without the override, manual mode, both saturation rails and the three clamp regions of the output adder each get their own directed case.

// File: rtl/bls_pkg.sv
`timescale 1ns/1ps
package bls_pkg;
    localparam int DATA_W       = 10;
    localparam int DAC_W        = 10;
    localparam int DLY_W        = 16;
    localparam int TGT_W        = 8;
    localparam int WSEL_W       = 2;
    localparam int LSEL_W       = 3;
    localparam int WIN_LOG_BASE = 4;

    typedef enum logic [1:0] {
        MS_IDLE   = 2'd0,
        MS_DELAY  = 2'd1,
        MS_SAMPLE = 2'd2
    } meter_state_e;

    // A measurement result, kept in half ADC codes (one fractional bit).
    typedef struct packed {
        logic              valid;
        logic [DATA_W:0]   avg_h;
    } meas_t;

    function automatic logic [DATA_W-1:0] add_clamp(
        input logic [DATA_W-1:0]        px,
        input logic signed [DAC_W-1:0]  ofs
    );
        int s;
        s = int'(px) + int'(ofs);
        if (s < 0)
            s = 0;
        else if (s > (1 << DATA_W) - 1)
            s = (1 << DATA_W) - 1;
        return DATA_W'(s);
    endfunction
endpackage

// File: rtl/bls_line_meter.sv
`timescale 1ns/1ps
module bls_line_meter
    import bls_pkg::*;
#(
    parameter int DLY_W_P  = DLY_W,
    parameter int WSEL_W_P = WSEL_W,
    parameter int WLOG_P   = WIN_LOG_BASE
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic                 px_valid,
    input  logic [DATA_W-1:0]    px_data,
    input  logic                 hsync,
    input  logic                 coast,
    input  logic                 coast_ovr,
    input  logic [DLY_W_P-1:0]   delay,
    input  logic [WSEL_W_P-1:0]  win_sel,
    output meas_t                line_o
);
    localparam int WLOG_MAX = WLOG_P + (1 << WSEL_W_P) - 1;
    localparam int SUM_W    = DATA_W + WLOG_MAX;
    localparam int CNT_W    = (DLY_W_P > WLOG_MAX + 1) ? DLY_W_P : WLOG_MAX + 1;

    meter_state_e       state;
    logic [CNT_W-1:0]   cnt;
    logic [SUM_W-1:0]   sum;
    logic [SUM_W-1:0]   sum_nxt;
    logic [SUM_W-1:0]   sum_shr;
    logic [CNT_W-1:0]   win_last;
    logic [CNT_W-1:0]   dly_last;
    logic               hs_q;
    logic               fall;
    logic               trig;

    assign fall     = hs_q & ~hsync;
    assign trig     = fall & en & (~coast | coast_ovr);
    assign win_last = (CNT_W'(1) << (WLOG_P + int'(win_sel))) - CNT_W'(1);
    assign dly_last = CNT_W'(delay) - CNT_W'(1);

    always_comb begin
        sum_nxt = sum + SUM_W'(px_data);
        sum_shr = sum_nxt >> (WLOG_P - 1 + int'(win_sel));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= MS_IDLE;
            cnt    <= '0;
            sum    <= '0;
            hs_q   <= 1'b0;
            line_o <= '0;
        end else begin
            hs_q         <= hsync;
            line_o.valid <= 1'b0;
            if (!en) begin
                state <= MS_IDLE;
            end else if (trig) begin
                cnt   <= '0;
                sum   <= '0;
                state <= (delay == '0) ? MS_SAMPLE : MS_DELAY;
            end else if (px_valid) begin
                case (state)
                    MS_DELAY: begin
                        if (cnt == dly_last) begin
                            cnt   <= '0;
                            state <= MS_SAMPLE;
                        end else begin
                            cnt <= cnt + CNT_W'(1);
                        end
                    end
                    MS_SAMPLE: begin
                        if (cnt == win_last) begin
                            line_o.valid <= 1'b1;
                            line_o.avg_h <= sum_shr[DATA_W:0];
                            state        <= MS_IDLE;
                        end else begin
                            sum <= sum_nxt;
                            cnt <= cnt + CNT_W'(1);
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R4: the skip counter never reaches the programmed delay
    p_delay_bound_r4: assert property (@(posedge clk) disable iff (rst)
        (state == MS_DELAY) |-> (cnt < CNT_W'(delay)));

    // R9: an edge seen while coasting without override starts nothing
    p_coast_gate_r9: assert property (@(posedge clk) disable iff (rst)
        (state == MS_IDLE && fall && coast && !coast_ovr) |=> (state == MS_IDLE));

    // R5: a line result only follows an accepted pixel in the window
    p_result_after_window_r5: assert property (@(posedge clk) disable iff (rst)
        line_o.valid |-> ($past(state) == MS_SAMPLE && $past(px_valid)));
endmodule

// File: rtl/bls_group_acc.sv
`timescale 1ns/1ps
module bls_group_acc
    import bls_pkg::*;
#(
    parameter int LSEL_W_P = LSEL_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  meas_t                line_i,
    input  logic [LSEL_W_P-1:0]  line_sel,
    output meas_t                grp_o
);
    localparam int LCNT_W = 1 << LSEL_W_P;
    localparam int ACC_W  = DATA_W + 1 + (1 << LSEL_W_P) - 1;

    logic [ACC_W-1:0]   acc;
    logic [ACC_W-1:0]   acc_nxt;
    logic [ACC_W-1:0]   acc_shr;
    logic [LCNT_W-1:0]  cnt;
    logic [LCNT_W-1:0]  lines_last;

    assign lines_last = (LCNT_W'(1) << line_sel) - LCNT_W'(1);

    always_comb begin
        acc_nxt = acc + ACC_W'(line_i.avg_h);
        acc_shr = acc_nxt >> line_sel;
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            acc   <= '0;
            cnt   <= '0;
            grp_o <= '0;
        end else begin
            grp_o.valid <= 1'b0;
            if (line_i.valid) begin
                if (cnt == lines_last) begin
                    grp_o.valid <= 1'b1;
                    grp_o.avg_h <= acc_shr[DATA_W:0];
                    acc         <= '0;
                    cnt         <= '0;
                end else begin
                    acc <= acc_nxt;
                    cnt <= cnt + LCNT_W'(1);
                end
            end
        end
    end

    // R6: the line counter stays inside the selected group
    p_group_count_r6: assert property (@(posedge clk) disable iff (rst)
        cnt <= lines_last);
endmodule

// File: rtl/bls_servo_step.sv
`timescale 1ns/1ps
module bls_servo_step
    import bls_pkg::*;
#(
    parameter int DAC_W_P = DAC_W,
    parameter int TGT_W_P = TGT_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       en,
    input  meas_t                      grp_i,
    input  logic                       half_mode,
    input  logic [TGT_W_P-1:0]         target,
    output logic signed [DAC_W_P-1:0]  code
);
    localparam int CMP_W = (DATA_W + 1 > TGT_W_P + 3) ? DATA_W + 1 : TGT_W_P + 3;
    localparam logic signed [DAC_W_P-1:0] CODE_MAX = {1'b0, {(DAC_W_P-1){1'b1}}};
    localparam logic signed [DAC_W_P-1:0] CODE_MIN = {1'b1, {(DAC_W_P-1){1'b0}}};

    logic [CMP_W-1:0] avg_cmp;
    logic [CMP_W-1:0] tgt_cmp;

    // Full range drops the half-code bit; both sides stay in half codes.
    always_comb begin
        avg_cmp = half_mode ? CMP_W'(grp_i.avg_h)
                            : CMP_W'({grp_i.avg_h[DATA_W:1], 1'b0});
        tgt_cmp = CMP_W'({target, 3'b000});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code <= '0;
        end else if (en && grp_i.valid) begin
            if (avg_cmp < tgt_cmp && code != CODE_MAX)
                code <= code + DAC_W_P'(1);
            else if (avg_cmp > tgt_cmp && code != CODE_MIN)
                code <= code - DAC_W_P'(1);
        end
    end

    // R7: the code moves only on the cycle after a group result
    p_hold_between_groups_r7: assert property (@(posedge clk) disable iff (rst)
        !grp_i.valid |=> $stable(code));

    // R8: no wrap from either rail
    p_sat_high_r8: assert property (@(posedge clk) disable iff (rst)
        (code == CODE_MAX) |=> (code != CODE_MIN));
    p_sat_low_r8: assert property (@(posedge clk) disable iff (rst)
        (code == CODE_MIN) |=> (code != CODE_MAX));
endmodule

// File: rtl/blk_level_servo.sv
`timescale 1ns/1ps
module blk_level_servo
    import bls_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       px_valid,
    input  logic [DATA_W-1:0]          px_data,
    input  logic                       hsync,
    input  logic                       pll_coast,
    input  logic                       cfg_manual,
    input  logic                       cfg_coast_override,
    input  logic                       cfg_half_range,
    input  logic [DLY_W-1:0]           cfg_delay,
    input  logic [WSEL_W-1:0]          cfg_win_sel,
    input  logic [LSEL_W-1:0]          cfg_lines_sel,
    input  logic [TGT_W-1:0]           cfg_target,
    input  logic signed [DAC_W-1:0]    cfg_user_ofs,
    output logic                       out_valid,
    output logic [DATA_W-1:0]          out_data,
    output logic signed [DAC_W-1:0]    dac_code
);
    logic                      loop_en;
    meas_t                     line_res;
    meas_t                     grp_res;
    logic signed [DAC_W-1:0]   servo_code;

    assign loop_en = ~cfg_manual;

    bls_line_meter #(
        .DLY_W_P  (DLY_W),
        .WSEL_W_P (WSEL_W),
        .WLOG_P   (WIN_LOG_BASE)
    ) u_meter (
        .clk       (clk),
        .rst       (rst),
        .en        (loop_en),
        .px_valid  (px_valid),
        .px_data   (px_data),
        .hsync     (hsync),
        .coast     (pll_coast),
        .coast_ovr (cfg_coast_override),
        .delay     (cfg_delay),
        .win_sel   (cfg_win_sel),
        .line_o    (line_res)
    );

    bls_group_acc #(
        .LSEL_W_P (LSEL_W)
    ) u_group (
        .clk      (clk),
        .rst      (rst),
        .en       (loop_en),
        .line_i   (line_res),
        .line_sel (cfg_lines_sel),
        .grp_o    (grp_res)
    );

    bls_servo_step #(
        .DAC_W_P (DAC_W),
        .TGT_W_P (TGT_W)
    ) u_servo (
        .clk       (clk),
        .rst       (rst),
        .en        (loop_en),
        .grp_i     (grp_res),
        .half_mode (cfg_half_range),
        .target    (cfg_target),
        .code      (servo_code)
    );

    assign dac_code = cfg_manual ? cfg_user_ofs : servo_code;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= px_valid;
            out_data  <= cfg_manual ? px_data : add_clamp(px_data, cfg_user_ofs);
        end
    end

    // R11: the output strobe is the input strobe one clock late
    p_strobe_delay_r11: assert property (@(posedge clk) disable iff (rst)
        $past(px_valid) |-> out_valid);

    // R2: in manual mode the sample passes through untouched
    p_manual_pass_r2: assert property (@(posedge clk) disable iff (rst)
        ($past(cfg_manual) && $past(px_valid)) |-> (out_data == $past(px_data)));
endmodule

// File: tb/tb_blk_level_servo.sv
`timescale 1ns/1ps
module tb_blk_level_servo;
    typedef struct packed {
        int dly;
        int wsel;
        int lsel;
        int tgt;
        int black;
        int half;
        int gaps;
    } vec_t;

    localparam int NVEC = 5;
    localparam vec_t VECS [NVEC] = '{
        '{dly: 20,  wsel: 0, lsel: 0, tgt: 4,  black: 40, half: 0, gaps: 0},
        '{dly: 5,   wsel: 1, lsel: 2, tgt: 10, black: 20, half: 0, gaps: 1},
        '{dly: 12,  wsel: 0, lsel: 1, tgt: 6,  black: 30, half: 1, gaps: 0},
        '{dly: 0,   wsel: 3, lsel: 0, tgt: 3,  black: 8,  half: 0, gaps: 0},
        '{dly: 300, wsel: 2, lsel: 3, tgt: 2,  black: 11, half: 0, gaps: 0}
    };
    localparam int BRIGHT = 1000;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               px_valid = 1'b0;
    logic [9:0]         px_data = '0;
    logic               hsync = 1'b0;
    logic               pll_coast = 1'b0;
    logic               cfg_manual = 1'b0;
    logic               cfg_coast_override = 1'b0;
    logic               cfg_half_range = 1'b0;
    logic [15:0]        cfg_delay = '0;
    logic [1:0]         cfg_win_sel = '0;
    logic [2:0]         cfg_lines_sel = '0;
    logic [7:0]         cfg_target = '0;
    logic signed [9:0]  cfg_user_ofs = '0;
    logic               out_valid;
    logic [9:0]         out_data;
    logic signed [9:0]  dac_code;

    int nchecks = 0;
    int nerr    = 0;
    int black   = 0;
    int gaps    = 0;

    always #2.5 clk = ~clk;

    blk_level_servo dut (
        .clk                (clk),
        .rst                (rst),
        .px_valid           (px_valid),
        .px_data            (px_data),
        .hsync              (hsync),
        .pll_coast          (pll_coast),
        .cfg_manual         (cfg_manual),
        .cfg_coast_override (cfg_coast_override),
        .cfg_half_range     (cfg_half_range),
        .cfg_delay          (cfg_delay),
        .cfg_win_sel        (cfg_win_sel),
        .cfg_lines_sel      (cfg_lines_sel),
        .cfg_target         (cfg_target),
        .cfg_user_ofs       (cfg_user_ofs),
        .out_valid          (out_valid),
        .out_data           (out_data),
        .dac_code           (dac_code)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        nchecks++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Plant: ADC code = black + DAC effect (half step in half-range mode)
    function automatic int plant_adc();
        int d;
        int v;
        d = int'(dac_code);
        if (cfg_half_range)
            d = d >>> 1;
        v = black + d;
        if (v < 0) v = 0;
        if (v > 1023) v = 1023;
        return v;
    endfunction

    // mode 0: flat, 1: odd pixels +1, 2: first half -2, second half +2
    function automatic int window_px(input int idx, input int win, input int mode);
        int v;
        v = plant_adc();
        if (mode == 1 && (idx % 2) == 1) v = v + 1;
        if (mode == 2) v = (idx < win / 2) ? v - 2 : v + 2;
        return v;
    endfunction

    task automatic run_line(input int mode);
        int dly;
        int win;
        dly = int'(cfg_delay);
        win = 16 << cfg_win_sel;
        hsync    = 1'b1;
        px_valid = 1'b1;
        px_data  = 10'(BRIGHT);
        repeat (8) @(negedge clk);
        hsync = 1'b0;
        @(negedge clk);
        for (int i = 0; i < dly + win + 8; i++) begin
            if (gaps != 0 && (i % 4) == 3) begin
                px_valid = 1'b0;
                px_data  = 10'(BRIGHT);
                @(negedge clk);
            end
            px_valid = 1'b1;
            if (i >= dly && i < dly + win)
                px_data = 10'(window_px(i - dly, win, mode));
            else
                px_data = 10'(BRIGHT);
            @(negedge clk);
        end
    endtask

    task automatic restart(input int dly, input int wsel, input int lsel, input int tgt,
                           input int blk, input int half);
        rst = 1'b1;
        cfg_delay      = 16'(dly);
        cfg_win_sel    = 2'(wsel);
        cfg_lines_sel  = 3'(lsel);
        cfg_target     = 8'(tgt);
        cfg_half_range = 1'(half);
        cfg_manual     = 1'b0;
        cfg_coast_override = 1'b0;
        cfg_user_ofs   = '0;
        pll_coast      = 1'b0;
        black          = blk;
        gaps           = 0;
        hsync          = 1'b0;
        px_valid       = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        nchecks++;
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
        $finish;
    end

    initial begin
        int held;
        int groups;
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", "dac_code in reset", int'(dac_code), 0);
        check("R1", "out_valid in reset", int'(out_valid), 0);
        restart(4, 0, 0, 4, 40, 0);
        check("R1", "dac_code after reset", int'(dac_code), 0);
        check("R1", "out_valid after reset", int'(out_valid), 0);

        // Convergence vectors: R4 R5 R6 R7 R10 with bright data outside the window
        for (int v = 0; v < NVEC; v++) begin
            restart(VECS[v].dly, VECS[v].wsel, VECS[v].lsel, VECS[v].tgt,
                    VECS[v].black, VECS[v].half);
            gaps = VECS[v].gaps;
            groups = VECS[v].black - 4 * VECS[v].tgt;
            if (groups < 0) groups = -groups;
            groups = groups * (VECS[v].half != 0 ? 2 : 1) + 4;
            for (int l = 0; l < (groups << VECS[v].lsel); l++) run_line(0);
            check("R7", $sformatf("vec %0d settled level", v), plant_adc(), 4 * VECS[v].tgt);
            held = int'(dac_code);
            for (int l = 0; l < (2 << VECS[v].lsel); l++) run_line(0);
            check("R7", $sformatf("vec %0d code holds at target", v), int'(dac_code), held);
        end

        // R4: bright pixels inside the delay, with invalid gaps: one step up
        restart(30, 0, 0, 10, 20, 0);
        gaps = 1;
        run_line(0);
        check("R4", "step after delayed window", int'(dac_code), 1);

        // R3: no edge, no measurement; then one step per line
        restart(0, 0, 0, 10, 20, 0);
        hsync = 1'b0;
        px_valid = 1'b1;
        px_data = 10'd20;
        repeat (200) @(negedge clk);
        check("R3", "no edge no step", int'(dac_code), 0);
        run_line(0);
        run_line(0);
        run_line(0);
        check("R3", "one step per line", int'(dac_code), 3);

        // R5: split window 14/18 averages 16 only for a 32-pixel window
        restart(6, 1, 0, 4, 16, 0);
        run_line(2);
        check("R5", "32-pixel window average equals target", int'(dac_code), 0);

        // R6: group of four lines
        restart(3, 0, 2, 10, 20, 0);
        run_line(0);
        run_line(0);
        run_line(0);
        check("R6", "no step before group end", int'(dac_code), 0);
        run_line(0);
        check("R6", "step at group end", int'(dac_code), 1);

        // R9: coasting suppresses, override restores
        restart(5, 0, 0, 10, 20, 0);
        pll_coast = 1'b1;
        for (int l = 0; l < 5; l++) run_line(0);
        check("R9", "frozen while coasting", int'(dac_code), 0);
        cfg_coast_override = 1'b1;
        for (int l = 0; l < 3; l++) run_line(0);
        check("R9", "override measures while coasting", int'(dac_code), 3);
        cfg_coast_override = 1'b0;
        pll_coast = 1'b0;
        run_line(0);
        check("R9", "resumes after coast", int'(dac_code), 4);

        // R10: mean 16.5 against target 16
        restart(4, 0, 0, 4, 16, 1);
        run_line(1);
        check("R10", "half range steps down on half code", int'(dac_code), -1);
        restart(4, 0, 0, 4, 16, 0);
        run_line(1);
        check("R10", "full range holds on half code", int'(dac_code), 0);

        // R8: both rails
        restart(0, 0, 0, 255, 0, 0);
        for (int l = 0; l < 520; l++) run_line(0);
        check("R8", "upper rail", int'(dac_code), 511);
        restart(0, 0, 0, 0, 1023, 0);
        for (int l = 0; l < 520; l++) run_line(0);
        check("R8", "lower rail", int'(dac_code), -512);

        // R2: manual mode
        restart(2, 0, 0, 10, 20, 0);
        cfg_manual = 1'b1;
        cfg_user_ofs = -10'sd37;
        @(negedge clk);
        check("R2", "manual code follows user offset", int'(dac_code), -37);
        run_line(0);
        run_line(0);
        px_valid = 1'b1;
        px_data = 10'd500;
        @(negedge clk);
        check("R2", "manual passthrough", int'(out_data), 500);
        cfg_user_ofs = 10'sd100;
        #1;
        check("R2", "manual code tracks change", int'(dac_code), 100);
        @(negedge clk);
        cfg_manual = 1'b0;
        cfg_user_ofs = '0;
        @(negedge clk);
        check("R2", "servo untouched by manual lines", int'(dac_code), 0);

        // R11: digital offset adder and clamps
        cfg_user_ofs = 10'sd25;
        px_valid = 1'b1;
        px_data = 10'd500;
        @(negedge clk);
        check("R11", "adder mid range", int'(out_data), 525);
        check("R11", "strobe follows", int'(out_valid), 1);
        cfg_user_ofs = -10'sd100;
        px_data = 10'd50;
        @(negedge clk);
        check("R11", "clamp at zero", int'(out_data), 0);
        cfg_user_ofs = 10'sd200;
        px_data = 10'd1000;
        @(negedge clk);
        check("R11", "clamp at top", int'(out_data), 1023);
        px_valid = 1'b0;
        @(negedge clk);
        check("R11", "strobe drops", int'(out_valid), 0);

        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
        $finish;
    end
endmodule